// File: doc/BRIEF.md
# Serial Link Out-of-Band Sequencer

This block runs the host end of the out-of-band power-up handshake on a serial storage link. It sees the line only as a per-cycle "burst present" flag from an external squelch detector and drives one "send burst" request to the transmitter. Every out-of-band signal is a train of short bursts, and all bursts have the same content. Only the idle time between bursts tells one signal from another. A long gap (about 320 ns) marks the reset/init class. A short gap (about 106.7 ns) marks the wake class.

After reset the host sends a reset train and waits for the device's init train. It then sends a wake train and waits for the device's wake train. Once the last idle gap of that train has elapsed, it declares the link ready. If a waiting phase runs too long, the block shows a timeout for a few cycles and starts the handshake again from the reset train.

The gap windows and the transmitted gap lengths are computed at elaboration time from the clock frequency parameter. The accepted windows are nominal ±10 %.

Top module: `oob_link_sequencer`

## Requirements
- R1: While `rst` is high, `send_burst`, `link_ready` and `timed_out` are all 0, and a second reset clears a previously reached ready state.
- R2: After reset the host emits a reset train: TX_BURSTS (6) bursts, each BURST_CYC (8) cycles high, separated by the nominal long gap (16 cycles at 50 MHz).
- R3: An idle gap, measured in cycles between the end of one received burst and the start of the next, is classed as long if it lies in 15..17 cycles and short if it is exactly 5 cycles (50 MHz defaults). Any other gap, including 18 cycles, belongs to neither class.
- R4: A received signal counts as detected only after MIN_GAPS (3) consecutive gaps of the same class, which means four bursts. Fewer bursts, or a run broken by an unclassed gap, detect nothing.
- R5: While waiting for the device init train, short-gap (wake class) trains are ignored and no transmission starts.
- R6: Once a long-gap train is detected while waiting for init, the host emits a wake train: 6 bursts of 8 high cycles separated by 5-cycle gaps.
- R7: `link_ready` rises only after a short-gap train has been detected while waiting for wake and the line has then stayed idle longer than the short window (more than 5 cycles). It then stays high until reset.
- R8: If no init train is detected within INIT_WAIT_CYC cycles of entering the init wait, `timed_out` is high for HOLD_CYC cycles, after which a fresh reset train is sent.
- R9: If the wake wait lasts WAKE_WAIT_CYC cycles without reaching ready, `timed_out` is raised the same way and `link_ready` stays low.
- R10: `link_ready` and `timed_out` are never high together, and `send_burst` is 0 while ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, CLK_MHZ MHz |
| rst | input | 1 | Synchronous active-high reset |
| burst_present | input | 1 | High in cycles where the receiver sees burst activity |
| send_burst | output | 1 | Request to the transmitter to emit burst content |
| link_ready | output | 1 | Handshake completed |
| timed_out | output | 1 | A waiting phase expired; restart is pending |

## Verification
The detector is given trains at the exact edges of the long window (15 and 17 cycles) and one cycle beyond it (18). This shows whether the window bounds are inclusive and computed correctly. Correct-class trains with only three bursts test whether the run length is enforced. Short-gap trains sent during the init wait show that one class is not taken for the other. The device wake train is followed by idle time that is sampled after 3 cycles and again after 12. This separates a ready asserted on detection from one asserted after the final gap. Runs with no device answer in each waiting phase exercise both timeouts and the restart.

// File: rtl/oob_pkg.sv
package oob_pkg;

  typedef enum logic [2:0] {
    ST_RESET_TX, ST_WAIT_INIT, ST_WAKE_TX, ST_WAIT_WAKE, ST_READY, ST_TIMEOUT
  } seq_state_t;

  typedef enum logic [1:0] {GAP_NONE, GAP_LONG, GAP_SHORT} gap_cls_t;

  // nominal gap lengths in tenths of a nanosecond
  localparam int LONG_GAP_DNS  = 3200;
  localparam int SHORT_GAP_DNS = 1067;

  // smallest cycle count not below 90 % of the nominal time
  function automatic int win_lo(input int dns, input int mhz);
    return (dns * 9 * mhz + 99999) / 100000;
  endfunction

  // largest cycle count not above 110 % of the nominal time
  function automatic int win_hi(input int dns, input int mhz);
    return (dns * 11 * mhz) / 100000;
  endfunction

  // nominal time rounded to whole cycles
  function automatic int win_nom(input int dns, input int mhz);
    return (dns * mhz + 5000) / 10000;
  endfunction

endpackage

// File: rtl/oob_gap_classifier.sv
module oob_gap_classifier
  import oob_pkg::*;
#(
  parameter int CLK_MHZ  = 50,
  parameter int MIN_GAPS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic burst_in,
  output logic det_long,
  output logic det_short,
  output logic quiet
);
  localparam int LONG_LO  = win_lo(LONG_GAP_DNS, CLK_MHZ);
  localparam int LONG_HI  = win_hi(LONG_GAP_DNS, CLK_MHZ);
  localparam int SHORT_LO = win_lo(SHORT_GAP_DNS, CLK_MHZ);
  localparam int SHORT_HI = win_hi(SHORT_GAP_DNS, CLK_MHZ);
  localparam int GAP_SAT  = LONG_HI + 1;
  localparam int GW       = $clog2(GAP_SAT + 1);
  localparam int RW       = $clog2(MIN_GAPS + 1);
  localparam logic [RW-1:0] RUN_FULL = RW'(MIN_GAPS);
  localparam logic [GW-1:0] GAP_TOP  = GW'(GAP_SAT);

  logic          prev_q, armed_q, det_long_q, det_short_q;
  logic [GW-1:0] gap_q;
  logic [RW-1:0] run_q, run_nx;
  gap_cls_t      cls_q, cls_nx, gap_cls;
  logic          rise, hit;

  function automatic gap_cls_t classify(input logic [GW-1:0] g);
    if (int'(g) >= LONG_LO && int'(g) <= LONG_HI)        return GAP_LONG;
    else if (int'(g) >= SHORT_LO && int'(g) <= SHORT_HI) return GAP_SHORT;
    else                                                 return GAP_NONE;
  endfunction

  assign rise    = burst_in && !prev_q && armed_q;
  assign gap_cls = classify(gap_q);

  always_comb begin
    cls_nx = cls_q;
    run_nx = run_q;
    if (rise) begin
      if (gap_cls == GAP_NONE) begin
        cls_nx = GAP_NONE;
        run_nx = '0;
      end else if (gap_cls == cls_q) begin
        if (run_q != RUN_FULL) run_nx = run_q + RW'(1);
      end else begin
        cls_nx = gap_cls;
        run_nx = RW'(1);
      end
    end
  end

  assign hit = rise && (gap_cls != GAP_NONE) && (run_nx == RUN_FULL) &&
               !((gap_cls == cls_q) && (run_q == RUN_FULL));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q      <= 1'b0;
      armed_q     <= 1'b0;
      gap_q       <= '0;
      cls_q       <= GAP_NONE;
      run_q       <= '0;
      det_long_q  <= 1'b0;
      det_short_q <= 1'b0;
    end else begin
      prev_q <= burst_in;
      if (burst_in) begin
        armed_q <= 1'b1;
        gap_q   <= '0;
      end else if (gap_q != GAP_TOP) begin
        gap_q <= gap_q + GW'(1);
      end
      cls_q       <= cls_nx;
      run_q       <= run_nx;
      det_long_q  <= hit && (gap_cls == GAP_LONG);
      det_short_q <= hit && (gap_cls == GAP_SHORT);
    end
  end

  assign det_long  = det_long_q;
  assign det_short = det_short_q;
  assign quiet     = armed_q && !prev_q && (int'(gap_q) > SHORT_HI);

endmodule

// File: rtl/oob_burst_tx.sv
module oob_burst_tx
  import oob_pkg::*;
#(
  parameter int CLK_MHZ   = 50,
  parameter int BURST_CYC = 8,
  parameter int TX_BURSTS = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic short_kind,
  output logic send_burst,
  output logic done
);
  localparam int LONG_GAP  = win_nom(LONG_GAP_DNS, CLK_MHZ);
  localparam int SHORT_GAP = win_nom(SHORT_GAP_DNS, CLK_MHZ);
  localparam int GAP_MAX   = (LONG_GAP > SHORT_GAP) ? LONG_GAP : SHORT_GAP;
  localparam int PW        = $clog2(BURST_CYC + GAP_MAX + 1);
  localparam int BW        = $clog2(TX_BURSTS + 1);

  logic [PW-1:0] pos_q;
  logic [BW-1:0] idx_q;
  logic          send_q, last_pos;
  int            period_last;

  assign period_last = BURST_CYC + (short_kind ? SHORT_GAP : LONG_GAP) - 1;
  assign last_pos    = (int'(pos_q) == period_last);
  assign done        = go && last_pos && (int'(idx_q) == TX_BURSTS - 1);

  always_ff @(posedge clk) begin
    if (rst || !go) begin
      pos_q  <= '0;
      idx_q  <= '0;
      send_q <= 1'b0;
    end else begin
      send_q <= (int'(pos_q) < BURST_CYC);
      if (last_pos) begin
        pos_q <= '0;
        idx_q <= done ? '0 : idx_q + BW'(1);
      end else begin
        pos_q <= pos_q + PW'(1);
      end
    end
  end

  assign send_burst = send_q;

endmodule

// File: rtl/oob_link_sequencer.sv
module oob_link_sequencer
  import oob_pkg::*;
#(
  parameter int CLK_MHZ       = 50,
  parameter int BURST_CYC     = 8,
  parameter int TX_BURSTS     = 6,
  parameter int MIN_GAPS      = 3,
  parameter int INIT_WAIT_CYC = 20000,
  parameter int WAKE_WAIT_CYC = 20000,
  parameter int HOLD_CYC      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic burst_present,
  output logic send_burst,
  output logic link_ready,
  output logic timed_out
);
  localparam int WAIT_MAX = (INIT_WAIT_CYC > WAKE_WAIT_CYC) ? INIT_WAIT_CYC : WAKE_WAIT_CYC;
  localparam int TMAX     = (WAIT_MAX > HOLD_CYC) ? WAIT_MAX : HOLD_CYC;
  localparam int TW       = $clog2(TMAX + 1);

  seq_state_t    state_q, state_nx;
  logic [TW-1:0] timer_q;
  logic          wake_seen_q;
  logic          det_init_w, det_wake_w, quiet_w, tx_done_w, tx_go_w, tx_short_w;
  logic          expire_w;
  int            limit_w;

  oob_gap_classifier #(.CLK_MHZ(CLK_MHZ), .MIN_GAPS(MIN_GAPS)) rx_i (
    .clk(clk), .rst(rst), .burst_in(burst_present),
    .det_long(det_init_w), .det_short(det_wake_w), .quiet(quiet_w)
  );

  assign tx_go_w    = (state_q == ST_RESET_TX) || (state_q == ST_WAKE_TX);
  assign tx_short_w = (state_q == ST_WAKE_TX);

  oob_burst_tx #(.CLK_MHZ(CLK_MHZ), .BURST_CYC(BURST_CYC), .TX_BURSTS(TX_BURSTS)) tx_i (
    .clk(clk), .rst(rst), .go(tx_go_w), .short_kind(tx_short_w),
    .send_burst(send_burst), .done(tx_done_w)
  );

  always_comb begin
    case (state_q)
      ST_WAIT_INIT: limit_w = INIT_WAIT_CYC;
      ST_WAIT_WAKE: limit_w = WAKE_WAIT_CYC;
      default:      limit_w = HOLD_CYC;
    endcase
  end
  assign expire_w = (int'(timer_q) == limit_w - 1);

  always_comb begin
    state_nx = state_q;
    case (state_q)
      ST_RESET_TX:  if (tx_done_w) state_nx = ST_WAIT_INIT;
      ST_WAIT_INIT: if (det_init_w) state_nx = ST_WAKE_TX;
                    else if (expire_w) state_nx = ST_TIMEOUT;
      ST_WAKE_TX:   if (tx_done_w) state_nx = ST_WAIT_WAKE;
      ST_WAIT_WAKE: if (wake_seen_q && quiet_w) state_nx = ST_READY;
                    else if (expire_w) state_nx = ST_TIMEOUT;
      ST_TIMEOUT:   if (expire_w) state_nx = ST_RESET_TX;
      default:      state_nx = state_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_RESET_TX;
      timer_q     <= '0;
      wake_seen_q <= 1'b0;
    end else begin
      state_q <= state_nx;
      if (state_nx != state_q) timer_q <= '0;
      else if (state_q == ST_WAIT_INIT || state_q == ST_WAIT_WAKE || state_q == ST_TIMEOUT)
        timer_q <= timer_q + TW'(1);
      if (state_q != ST_WAIT_WAKE) wake_seen_q <= 1'b0;
      else if (det_wake_w)         wake_seen_q <= 1'b1;
    end
  end

  assign link_ready = (state_q == ST_READY);
  assign timed_out  = (state_q == ST_TIMEOUT);

endmodule

// File: rtl/oob_link_sequencer_chk.sv
module oob_link_sequencer_chk
  import oob_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       send_burst,
  input logic       link_ready,
  input logic       timed_out,
  input logic       det_init,
  input logic       det_wake,
  input logic       quiet,
  input logic       wake_seen,
  input seq_state_t st
);
  // R10
  excl_ready_timeout_chk: assert property (@(posedge clk) disable iff (rst)
    !(link_ready && timed_out));

  // R10
  silent_when_ready_chk: assert property (@(posedge clk) disable iff (rst)
    link_ready |-> !send_burst);

  // R7
  ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    link_ready |=> link_ready);

  // R7
  ready_after_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(link_ready) |-> $past(quiet && wake_seen));

  // R4
  single_class_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({det_init, det_wake}));

  // R5
  wake_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT_INIT && det_wake) |=> (st != ST_WAKE_TX));

  // R6
  init_advances_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT_INIT && det_init) |=> (st == ST_WAKE_TX));

  // R8
  timeout_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timed_out) |-> $past(st == ST_WAIT_INIT || st == ST_WAIT_WAKE));

endmodule

bind oob_link_sequencer oob_link_sequencer_chk chk_i (
  .clk(clk), .rst(rst), .send_burst(send_burst), .link_ready(link_ready),
  .timed_out(timed_out), .det_init(det_init_w), .det_wake(det_wake_w),
  .quiet(quiet_w), .wake_seen(wake_seen_q), .st(state_q)
);

// File: tb/oob_link_sequencer_tb.sv
module oob_link_sequencer_tb_top;
  localparam int BURST     = 8;
  localparam int NB        = 6;
  localparam int LONG_GAP  = 16;
  localparam int SHORT_GAP = 5;
  localparam int INIT_WAIT = 1000;
  localparam int WAKE_WAIT = 600;
  localparam int HOLD      = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bp  = 1'b0;
  logic send_burst, link_ready, timed_out;

  int checks = 0;
  int fails  = 0;
  int tx_high_cnt = 0;
  bit finished = 0;

  int    exp_q[$];
  string req_q[$];

  always #10 clk = ~clk;

  oob_link_sequencer #(
    .CLK_MHZ(50), .BURST_CYC(BURST), .TX_BURSTS(NB), .MIN_GAPS(3),
    .INIT_WAIT_CYC(INIT_WAIT), .WAKE_WAIT_CYC(WAKE_WAIT), .HOLD_CYC(HOLD)
  ) dut_i (
    .clk(clk), .rst(rst), .burst_present(bp),
    .send_burst(send_burst), .link_ready(link_ready), .timed_out(timed_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // driver: expected transmit train as run lengths (high = n, low = 1000+n)
  task automatic expect_tx(input int gap, input string req);
    for (int i = 0; i < NB; i++) begin
      exp_q.push_back(BURST); req_q.push_back(req);
      if (i < NB - 1) begin
        exp_q.push_back(1000 + gap); req_q.push_back(req);
      end
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dev_send(input int gap, input int n);
    for (int i = 0; i < n; i++) begin
      bp = 1'b1; cyc(BURST);
      bp = 1'b0; cyc(gap);
    end
  endtask

  task automatic score(input int item);
    int e; string r;
    if (exp_q.size() == 0) begin
      check(0, "R2", "unexpected transmit run", item, 0);
    end else begin
      e = exp_q.pop_front(); r = req_q.pop_front();
      check(item == e, r, "transmit run", item, e);
    end
  endtask

  // monitor: measure send_burst runs and compare against the queue
  bit prev_s = 0; int run_len = 0; bit lo_ok = 0;
  always @(negedge clk) begin
    if (rst) begin
      prev_s = 0; run_len = 0; lo_ok = 0;
    end else begin
      if (send_burst) tx_high_cnt++;
      if (send_burst == prev_s) run_len++;
      else begin
        if (prev_s) begin score(run_len); lo_ok = 1; end
        else if (lo_ok && run_len <= 40) score(1000 + run_len);
        prev_s = send_burst; run_len = 1;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "R8", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int t, u, h0;
    cyc(5);
    check(send_burst == 0, "R1", "send_burst in reset", send_burst, 0);
    check(link_ready == 0, "R1", "link_ready in reset", link_ready, 0);
    check(timed_out == 0,  "R1", "timed_out in reset", timed_out, 0);
    expect_tx(LONG_GAP, "R2");
    rst = 1'b0;

    // no device answer: init wait expires (R8)
    t = 0;
    while (!timed_out && t < 3000) begin cyc(1); t++; end
    check(t >= 1140 && t <= 1150, "R8", "cycles to init timeout", t, 1144);
    expect_tx(LONG_GAP, "R8");
    u = 0;
    while (timed_out && u < 100) begin cyc(1); u++; end
    check(u == HOLD, "R8", "timeout hold length", u, HOLD);
    cyc(150);

    // wrong class, out of window, too short: all ignored
    h0 = tx_high_cnt;
    dev_send(SHORT_GAP, 6); cyc(40);
    check(tx_high_cnt == h0, "R5", "tx cycles after short-gap train in init wait", tx_high_cnt - h0, 0);
    dev_send(18, 6); cyc(40);
    check(tx_high_cnt == h0, "R3", "tx cycles after 18-cycle gaps", tx_high_cnt - h0, 0);
    dev_send(LONG_GAP, 3); cyc(40);
    check(tx_high_cnt == h0, "R4", "tx cycles after three bursts", tx_high_cnt - h0, 0);
    check(timed_out == 0, "R8", "no timeout yet", timed_out, 0);

    // valid init train at upper window edge -> wake train (R3, R6)
    expect_tx(SHORT_GAP, "R6");
    dev_send(17, 6); cyc(30);
    check(tx_high_cnt - h0 == NB * BURST, "R6", "wake train high cycles", tx_high_cnt - h0, NB * BURST);
    check(link_ready == 0, "R7", "not ready before device wake", link_ready, 0);

    dev_send(SHORT_GAP, 3); cyc(30);
    check(link_ready == 0, "R4", "ready after three wake bursts", link_ready, 0);

    for (int i = 0; i < 5; i++) begin
      bp = 1'b1; cyc(BURST);
      bp = 1'b0;
      if (i < 4) cyc(SHORT_GAP);
    end
    cyc(3);
    check(link_ready == 0, "R7", "ready during final gap", link_ready, 0);
    cyc(9);
    check(link_ready == 1, "R7", "ready after final gap", link_ready, 1);
    cyc(50);
    check(link_ready == 1, "R7", "ready holds", link_ready, 1);
    check(send_burst == 0 && timed_out == 0, "R10", "quiet while ready",
          {30'd0, send_burst, timed_out}, 0);

    // second reset, lower window edge, then wake wait expires (R9)
    rst = 1'b1; cyc(3);
    check(link_ready == 0, "R1", "reset clears ready", link_ready, 0);
    expect_tx(LONG_GAP, "R2");
    rst = 1'b0;
    cyc(150);
    expect_tx(SHORT_GAP, "R6");
    dev_send(15, 6);
    t = 0;
    while (!timed_out && t < 2000) begin cyc(1); t++; end
    check(timed_out == 1, "R9", "wake wait timeout", timed_out, 1);
    check(link_ready == 0, "R9", "ready low on timeout", link_ready, 0);
    expect_tx(LONG_GAP, "R9");
    while (timed_out) cyc(1);
    cyc(150);
    check(exp_q.size() == 0, "R2", "expected runs left over", exp_q.size(), 0);
    finish_run();
  end
endmodule